// File: doc/BRIEF.md
# CAN Fault Confinement State Machine

This block keeps a CAN node's transmit and receive error counters and turns them into the node's error state: configuration, error active, error passive or bus-off. It also raises a warning flag once either counter gets near the passive threshold. The protocol engine feeds it with coded increment events and decrement pulses, and it never detects errors itself.

When the transmit counter would pass its maximum, the node goes bus-off and both counters clear. The way out of bus-off depends on host policy. If auto-recovery was latched while the core was disabled, recovery starts at once. Otherwise the node waits until the host sets the start-recovery bit. During recovery the receive counter counts pulses from the engine, one per run of 11 consecutive nominal recessive bits. After 128 such runs the node goes back to error active with clean counters.

Top module: `canFaultConfine`

## Requirements
- R1: `errState` uses the codes 2'b00 = configuration, 2'b01 = error active, 2'b11 = error passive and 2'b10 = bus-off. After reset, and while `coreEn` is 0, it reads 00 with both counters at 0. One cycle after `coreEn` rises it reads 01.
- R2: A counter increment code is applied in one cycle: 2'b00 adds nothing, 2'b01 adds 1, 2'b10 adds 8 and 2'b11 adds nothing. A decrement pulse subtracts 1 from the counter after its increment, and is ignored when that result is 0.
- R3: The receive counter saturates at 255. A transmit increment that would take the counter past 255 puts the node in bus-off (10), clears both counters and raises `busOffPulse` for one cycle.
- R4: While the node is running, the state is passive (11) when either counter is above 127, and active (01) when both are at or below 127.
- R5: `errWarn` is 1 exactly when either counter is at or above 96.
- R6: `softRst` and `coreEn` = 0 both clear both counters and return the state to 00.
- R7: While `snoopSel` is 1, both counters stay at 0 whatever error events arrive.
- R8: `autoRecoverIn` is captured only while `coreEn` is 0. When the captured value is 1, `recovering` rises in the same cycle that bus-off is entered.
- R9: When auto-recovery is off, the node stays in bus-off and ignores idle-sequence pulses until a `startRecoverSet` pulse arrives. That pulse sets `startRecoverBit` and `recovering`. A pulse outside bus-off has no effect.
- R10: While in bus-off, error events are ignored. During recovery each `idleSeq` pulse adds 1 to the receive counter. The 128th pulse returns the node to 01 with both counters at 0, raises `recoverDonePulse` for one cycle and clears `startRecoverBit` and `recovering`.
- R11: Disabling the core while in bus-off clears `startRecoverBit` and `recovering`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous hardware reset |
| softRst | input | 1 | Software reset pulse |
| coreEn | input | 1 | Core enable; 0 means configuration mode |
| snoopSel | input | 1 | Bus-monitor mode select |
| autoRecoverIn | input | 1 | Auto-recovery policy, captured while disabled |
| startRecoverSet | input | 1 | Host pulse that sets the start-recovery bit |
| txIncCode | input | 2 | Transmit counter increment code |
| txDec | input | 1 | Transmit counter decrement pulse |
| rxIncCode | input | 2 | Receive counter increment code |
| rxDec | input | 1 | Receive counter decrement pulse |
| idleSeq | input | 1 | Pulse for each run of 11 nominal recessive bits |
| txCount | output | 8 | Transmit error counter |
| rxCount | output | 8 | Receive error counter |
| errState | output | 2 | Error state code |
| errWarn | output | 1 | Error-warning flag |
| recovering | output | 1 | Bus-off recovery in progress |
| startRecoverBit | output | 1 | Host start-recovery request bit |
| busOffPulse | output | 1 | One-cycle pulse on bus-off entry |
| recoverDonePulse | output | 1 | One-cycle pulse on recovery completion |

## Verification
The assertions check several rules on every cycle:
- a held receive counter at 255 never moves under an increment;
- snoop mode forces zero counters;
- disable forces the configuration code;
- the recovery and start-recovery flags appear only in bus-off;
- the bus-off and done pulses come with cleared counters in the right state.

Other behaviours show up only in the bench's scenarios:
- the exact arithmetic of the increment codes;
- the thresholds at 96 and 127;
- the 128-sequence recovery count;
- the different exits from bus-off under automatic and host-requested policy.

// File: rtl/fcPkg.sv
package fcPkg;
  typedef enum logic [1:0] {
    ST_CFG     = 2'b00,
    ST_ACTIVE  = 2'b01,
    ST_BUSOFF  = 2'b10,
    ST_PASSIVE = 2'b11
  } errState_e;

  typedef enum logic [1:0] {
    MODE_CFG    = 2'b00,
    MODE_RUN    = 2'b01,
    MODE_BUSOFF = 2'b10
  } mode_e;

  typedef struct packed {
    logic clrAll;
    logic applyErr;
    logic idleStep;
  } cntStrobe_t;
endpackage

// File: rtl/fcCounters.sv
module fcCounters #(
  parameter int CNT_W        = 8,
  parameter int BIG_STEP     = 8,
  parameter int RECOVER_SEQS = 128
) (
  input  logic              clk,
  input  logic              rstN,
  input  fcPkg::cntStrobe_t strb,
  input  logic [1:0]        txIncCode,
  input  logic              txDec,
  input  logic [1:0]        rxIncCode,
  input  logic              rxDec,
  output logic [CNT_W-1:0]  txCnt,
  output logic [CNT_W-1:0]  rxCnt,
  output logic              txOverflow,
  output logic              recoveryLast
);
  localparam logic [CNT_W:0]   CNT_MAX = {1'b0, {CNT_W{1'b1}}};
  localparam logic [CNT_W-1:0] FULL    = {CNT_W{1'b1}};
  localparam logic [CNT_W-1:0] LAST    = CNT_W'(RECOVER_SEQS - 1);

  function automatic logic [CNT_W:0] stepOf(input logic [1:0] code);
    case (code)
      2'b01:   stepOf = (CNT_W+1)'(1);
      2'b10:   stepOf = (CNT_W+1)'(BIG_STEP);
      default: stepOf = '0;
    endcase
  endfunction

  logic [CNT_W:0] txSum, txAdj, rxSum, rxAdj;
  logic [CNT_W-1:0] txNext, rxNext;

  always_comb begin
    txSum = {1'b0, txCnt} + stepOf(txIncCode);
    txAdj = (txDec && txSum != '0) ? txSum - 1'b1 : txSum;
    rxSum = {1'b0, rxCnt} + stepOf(rxIncCode);
    rxAdj = (rxDec && rxSum != '0) ? rxSum - 1'b1 : rxSum;
    txOverflow   = txSum > CNT_MAX;
    recoveryLast = rxCnt == LAST;
    txNext = txAdj[CNT_W-1:0];
    rxNext = (rxAdj > CNT_MAX) ? FULL : rxAdj[CNT_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (!rstN || strb.clrAll) begin
      txCnt <= '0;
      rxCnt <= '0;
    end else if (strb.applyErr) begin
      txCnt <= txNext;
      rxCnt <= rxNext;
    end else if (strb.idleStep && rxCnt != FULL) begin
      rxCnt <= rxCnt + 1'b1;
    end
  end

  AST_RX_SATURATE: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rxCnt) == FULL && $past(strb.applyErr) && !$past(rxDec)
     && !$past(strb.clrAll)) |-> rxCnt == FULL); // R3
endmodule

// File: rtl/fcCtrl.sv
module fcCtrl #(
  parameter int CNT_W         = 8,
  parameter int PASSIVE_LIMIT = 127
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              softRst,
  input  logic              coreEn,
  input  logic              snoopSel,
  input  logic              autoRecoverIn,
  input  logic              startRecoverSet,
  input  logic              idleSeq,
  input  logic              txOverflow,
  input  logic              recoveryLast,
  input  logic [CNT_W-1:0]  txCnt,
  input  logic [CNT_W-1:0]  rxCnt,
  output fcPkg::cntStrobe_t strb,
  output fcPkg::errState_e  errState,
  output logic              recovering,
  output logic              startBit,
  output logic              busOffPulse,
  output logic              doneP
);
  import fcPkg::*;

  mode_e mode;
  logic  autoReg;
  logic  enterBusOff, finishRec;

  always_comb begin
    enterBusOff   = mode == MODE_RUN && !snoopSel && txOverflow;
    finishRec     = mode == MODE_BUSOFF && recovering && idleSeq && recoveryLast;
    strb.clrAll   = softRst || !coreEn || snoopSel || enterBusOff || finishRec;
    strb.applyErr = mode == MODE_RUN && !snoopSel && !txOverflow;
    strb.idleStep = mode == MODE_BUSOFF && recovering && idleSeq;
  end

  always_comb begin
    case (mode)
      MODE_RUN:    errState = (txCnt > CNT_W'(PASSIVE_LIMIT) || rxCnt > CNT_W'(PASSIVE_LIMIT))
                              ? ST_PASSIVE : ST_ACTIVE;
      MODE_BUSOFF: errState = ST_BUSOFF;
      default:     errState = ST_CFG;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN || softRst) begin
      mode <= MODE_CFG;  autoReg <= 1'b0;  startBit <= 1'b0;
      recovering <= 1'b0; busOffPulse <= 1'b0; doneP <= 1'b0;
    end else if (!coreEn) begin
      mode <= MODE_CFG;  autoReg <= autoRecoverIn;  startBit <= 1'b0;
      recovering <= 1'b0; busOffPulse <= 1'b0; doneP <= 1'b0;
    end else begin
      busOffPulse <= 1'b0;
      doneP       <= 1'b0;
      case (mode)
        MODE_CFG: mode <= MODE_RUN;
        MODE_RUN: if (enterBusOff) begin
          mode        <= MODE_BUSOFF;
          busOffPulse <= 1'b1;
          recovering  <= autoReg;
        end
        MODE_BUSOFF: begin
          if (startRecoverSet) startBit <= 1'b1;
          if (!recovering && (autoReg || startBit || startRecoverSet))
            recovering <= 1'b1;
          if (finishRec) begin
            mode       <= MODE_RUN;
            recovering <= 1'b0;
            startBit   <= 1'b0;
            doneP      <= 1'b1;
          end
        end
        default: mode <= MODE_CFG;
      endcase
    end
  end

  AST_CFG_WHEN_DISABLED: assert property (@(posedge clk) disable iff (!rstN)
    !$past(coreEn) |-> errState == ST_CFG); // R1
  AST_RECOVER_IN_BUSOFF: assert property (@(posedge clk) disable iff (!rstN)
    recovering |-> errState == ST_BUSOFF); // R10
  AST_START_IN_BUSOFF: assert property (@(posedge clk) disable iff (!rstN)
    startBit |-> errState == ST_BUSOFF); // R9
endmodule

// File: rtl/canFaultConfine.sv
module canFaultConfine #(
  parameter int CNT_W         = 8,
  parameter int BIG_STEP      = 8,
  parameter int WARN_LIMIT    = 96,
  parameter int PASSIVE_LIMIT = 127,
  parameter int RECOVER_SEQS  = 128
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             softRst,
  input  logic             coreEn,
  input  logic             snoopSel,
  input  logic             autoRecoverIn,
  input  logic             startRecoverSet,
  input  logic [1:0]       txIncCode,
  input  logic             txDec,
  input  logic [1:0]       rxIncCode,
  input  logic             rxDec,
  input  logic             idleSeq,
  output logic [CNT_W-1:0] txCount,
  output logic [CNT_W-1:0] rxCount,
  output logic [1:0]       errState,
  output logic             errWarn,
  output logic             recovering,
  output logic             startRecoverBit,
  output logic             busOffPulse,
  output logic             recoverDonePulse
);
  import fcPkg::*;

  cntStrobe_t strb;
  errState_e  stateCode;
  logic       txOverflow, recoveryLast;

  fcCounters #(.CNT_W(CNT_W), .BIG_STEP(BIG_STEP), .RECOVER_SEQS(RECOVER_SEQS)) uCnt (
    .clk(clk), .rstN(rstN), .strb(strb),
    .txIncCode(txIncCode), .txDec(txDec), .rxIncCode(rxIncCode), .rxDec(rxDec),
    .txCnt(txCount), .rxCnt(rxCount),
    .txOverflow(txOverflow), .recoveryLast(recoveryLast)
  );

  fcCtrl #(.CNT_W(CNT_W), .PASSIVE_LIMIT(PASSIVE_LIMIT)) uCtrl (
    .clk(clk), .rstN(rstN), .softRst(softRst), .coreEn(coreEn), .snoopSel(snoopSel),
    .autoRecoverIn(autoRecoverIn), .startRecoverSet(startRecoverSet), .idleSeq(idleSeq),
    .txOverflow(txOverflow), .recoveryLast(recoveryLast),
    .txCnt(txCount), .rxCnt(rxCount),
    .strb(strb), .errState(stateCode), .recovering(recovering),
    .startBit(startRecoverBit), .busOffPulse(busOffPulse), .doneP(recoverDonePulse)
  );

  assign errState = stateCode;
  assign errWarn  = (txCount >= CNT_W'(WARN_LIMIT)) || (rxCount >= CNT_W'(WARN_LIMIT));

  AST_SNOOP_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    $past(snoopSel) |-> (txCount == '0 && rxCount == '0)); // R7
  AST_BUSOFF_CLEAN: assert property (@(posedge clk) disable iff (!rstN)
    busOffPulse |-> (errState == 2'b10 && txCount == '0 && rxCount == '0)); // R3
  AST_DONE_ACTIVE: assert property (@(posedge clk) disable iff (!rstN)
    recoverDonePulse |-> (errState == 2'b01 && txCount == '0 && rxCount == '0)); // R10
endmodule

// File: tb/tb_canFaultConfine.sv
module tb_canFaultConfine;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 8;
  // {txCode, txDec, rxCode, rxDec, expTx, expRx, expState}
  localparam logic [23:0] VEC [NVEC] = '{
    {2'b01, 1'b0, 2'b00, 1'b0, 8'd1,  8'd0,  2'b01},
    {2'b10, 1'b0, 2'b00, 1'b0, 8'd9,  8'd0,  2'b01},
    {2'b00, 1'b0, 2'b10, 1'b0, 8'd9,  8'd8,  2'b01},
    {2'b00, 1'b0, 2'b01, 1'b1, 8'd9,  8'd8,  2'b01},
    {2'b00, 1'b1, 2'b00, 1'b1, 8'd8,  8'd7,  2'b01},
    {2'b11, 1'b0, 2'b00, 1'b0, 8'd8,  8'd7,  2'b01},
    {2'b00, 1'b0, 2'b10, 1'b0, 8'd8,  8'd15, 2'b01},
    {2'b00, 1'b1, 2'b01, 1'b0, 8'd7,  8'd16, 2'b01}
  };

  logic clk = 0;
  logic rstN, softRst, coreEn, snoopSel, autoRecoverIn, startRecoverSet;
  logic [1:0] txIncCode, rxIncCode;
  logic txDec, rxDec, idleSeq;
  logic [7:0] txCount, rxCount;
  logic [1:0] errState;
  logic errWarn, recovering, startRecoverBit, busOffPulse, recoverDonePulse;
  int nChecks = 0, nFails = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  canFaultConfine dut (.*);

  task automatic chk(input string tag, input int act, input int exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic toBusOff();
    txIncCode = 2'b10;
    repeat (32) tick();
    txIncCode = 2'b00;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nChecks++; nFails++;
    $display("FAIL watchdog actual=1 expected=0");
    $display("TB_RESULT checks=%0d failures=%0d", nChecks, nFails);
    $finish;
  end

  initial begin
    rstN = 0; softRst = 0; coreEn = 0; snoopSel = 0; autoRecoverIn = 0;
    startRecoverSet = 0; txIncCode = 0; rxIncCode = 0; txDec = 0; rxDec = 0; idleSeq = 0;
    repeat (3) tick();
    rstN = 1; tick();
    chk("R1 reset state", errState, 0);
    chk("R1 reset tx", txCount, 0);
    chk("R1 reset rx", rxCount, 0);
    chk("R5 reset warn", errWarn, 0);
    coreEn = 1; tick();
    chk("R1 enabled active", errState, 1);

    for (int i = 0; i < NVEC; i++) begin
      {txIncCode, txDec, rxIncCode, rxDec} = VEC[i][23:18];
      tick();
      chk("R2 vector tx", txCount, VEC[i][17:10]);
      chk("R2 vector rx", rxCount, VEC[i][9:2]);
      chk("R4 vector state", errState, VEC[i][1:0]);
    end
    {txIncCode, txDec, rxIncCode, rxDec} = '0;

    rxIncCode = 2'b10; repeat (9) tick();
    chk("R5 warn below 96", errWarn, 0);
    tick();
    chk("R5 rx at 96", rxCount, 96);
    chk("R5 warn at 96", errWarn, 1);
    repeat (4) tick();
    chk("R4 passive at 128", errState, 3);
    rxIncCode = 2'b00; rxDec = 1; tick(); rxDec = 0;
    chk("R4 back active at 127", errState, 1);
    rxIncCode = 2'b10; repeat (20) tick();
    chk("R3 rx saturates", rxCount, 255);
    rxIncCode = 2'b01; tick(); rxIncCode = 2'b00;
    chk("R3 rx holds 255", rxCount, 255);

    softRst = 1; tick(); softRst = 0;
    chk("R6 soft reset rx", rxCount, 0);
    chk("R6 soft reset state", errState, 0);
    tick();
    rxIncCode = 2'b10; tick(); rxIncCode = 2'b00;
    coreEn = 0; tick();
    chk("R6 disable rx", rxCount, 0);
    chk("R6 disable state", errState, 0);
    coreEn = 1; tick();

    snoopSel = 1; txIncCode = 2'b10; rxIncCode = 2'b10; tick();
    chk("R7 snoop tx", txCount, 0);
    chk("R7 snoop rx", rxCount, 0);
    snoopSel = 0; txIncCode = 0; rxIncCode = 0; tick();

    startRecoverSet = 1; tick(); startRecoverSet = 0;
    chk("R9 start ignored when active", startRecoverBit, 0);

    txIncCode = 2'b10; repeat (31) tick(); txIncCode = 2'b00;
    chk("R3 tx at 248", txCount, 248);
    chk("R4 passive tx", errState, 3);
    txIncCode = 2'b10; tick(); txIncCode = 2'b00;
    chk("R3 busoff state", errState, 2);
    chk("R3 busoff tx clear", txCount, 0);
    chk("R3 busoff pulse", busOffPulse, 1);
    chk("R9 no auto recovery", recovering, 0);
    idleSeq = 1; repeat (3) tick(); idleSeq = 0;
    chk("R9 idle ignored waiting", rxCount, 0);
    chk("R9 still busoff", errState, 2);
    chk("R3 pulse one cycle", busOffPulse, 0);
    txIncCode = 2'b10; tick(); txIncCode = 2'b00;
    chk("R10 errors ignored busoff", txCount, 0);
    startRecoverSet = 1; tick(); startRecoverSet = 0;
    chk("R9 start bit set", startRecoverBit, 1);
    chk("R9 recovering", recovering, 1);
    idleSeq = 1; repeat (127) tick();
    chk("R10 rx counts seqs", rxCount, 127);
    chk("R10 still busoff", errState, 2);
    tick(); idleSeq = 0;
    chk("R10 active again", errState, 1);
    chk("R10 rx cleared", rxCount, 0);
    chk("R10 done pulse", recoverDonePulse, 1);
    chk("R10 start bit cleared", startRecoverBit, 0);
    chk("R10 recovering cleared", recovering, 0);
    tick();
    chk("R10 done pulse one cycle", recoverDonePulse, 0);

    coreEn = 0; autoRecoverIn = 1; tick();
    coreEn = 1; autoRecoverIn = 0; tick();
    toBusOff();
    chk("R8 busoff pulse", busOffPulse, 1);
    chk("R8 auto recovering", recovering, 1);
    chk("R8 start bit idle", startRecoverBit, 0);
    idleSeq = 1; repeat (128) tick(); idleSeq = 0;
    chk("R8 auto recovered", errState, 1);

    coreEn = 0; tick(); coreEn = 1; tick();
    toBusOff();
    chk("R8 policy now manual", recovering, 0);
    startRecoverSet = 1; tick(); startRecoverSet = 0;
    chk("R11 start bit set", startRecoverBit, 1);
    coreEn = 0; tick();
    chk("R11 start bit cleared", startRecoverBit, 0);
    chk("R11 recovering cleared", recovering, 0);
    chk("R11 state config", errState, 0);

    $display("TB_RESULT checks=%0d failures=%0d", nChecks, nFails);
    $finish;
  end
endmodule